// File: doc/BRIEF.md
# Fractional Microsecond Tick Counter

This block derives a steady 1 MHz time base from a reference clock whose frequency need not be a whole number of megahertz. A rational prescaler emits, on average, a programmable number of ticks for every programmable number of reference cycles. This gives an exact long-run 1 MHz rate from clocks such as 12, 13, 19.2 or 38.4 MHz. Each tick advances a 32-bit free-running microsecond counter.

Software reaches the block through a small register port. The port has a 16-bit ratio word, a read-only view of the counter and a single-bit freeze control. The block drives a one-cycle tick pulse and the current count. Working out the right ratio for a given reference frequency is left to software.

Top module: `usec_tick_counter`

## Requirements
- R1: After a synchronous active-low reset, the count is 0 and the tick output is low. The ratio word reads 0x000b and freeze reads 0.
- R2: The ratio word holds two fields, each stored as its value minus one. Bits [7:0] give D-1, where D is the number of reference cycles per group. Bits [15:8] give N-1, where N is the number of ticks per group. Each unfrozen reference cycle adds N to a phase accumulator. When the sum reaches D, a tick is emitted and D is subtracted. The tick output is registered: it goes high in the cycle after the edge on which the sum reached D.
- R3: Only one tick is emitted per reference cycle, whatever the ratio. When N exceeds D, a tick appears on every unfrozen cycle.
- R4: The counter only counts upward. It advances by exactly one, modulo 2^32, on the same edge that raises the tick output. At all other times it holds.
- R5: A write to the ratio word at offset 0x14 clears the accumulator, so the new ratio starts from phase zero. With 0x000b, the first tick follows the 12th edge after the write edge.
- R6: While freeze (bit 0 of offset 0x4c) is set, the accumulator and the counter hold and no tick is emitted. A write to freeze takes effect from the following edge.
- R7: When a ratio write lands on the edge where a tick would otherwise be due, the write wins. No tick is emitted and the counter does not advance.
- R8: Writes to the counter offset 0x10 and to unmapped offsets change nothing. Unmapped offsets read as zero.
- R9: Reads are combinational. Offset 0x10 returns the count. Offset 0x14 returns the 16-bit ratio word in bits [15:0], with zeros above. Offset 0x4c returns freeze in bit 0. Write data above bit 15 is dropped for the ratio word.
- R10: With ratio 0x045f, exactly 5 ticks fall in each 96 unfrozen cycles. With 0x000c, exactly 1 tick falls in each 13 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| tick_o | output | 1 | One-cycle 1 MHz tick pulse |
| count_o | output | 32 | Microsecond count |

## Verification
A ratio write and a due tick can fall on the same edge. So can a freeze change and an accumulation. The bench provokes the first case on purpose: it writes a new ratio exactly on the edge where the running ratio would complete a group. It then judges that edge by checking that the tick stays low and the count is unchanged. Random stimulus mixes ratio writes, freeze toggles and ignored writes across arbitrary phases. A bench reference model predicts every cycle's tick, count and read data.

// File: rtl/usec_pkg.sv
// Package: shared offsets and the ratio word layout for the microsecond
// tick counter. Assumes an 8-bit byte-offset register space.
package usec_pkg;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int FIELD_W = 8;

    localparam logic [ADDR_W-1:0] OFF_COUNT = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_RATIO = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_HOLD  = 8'h4c;

    // High byte: ticks per group minus one; low byte: cycles per group minus one.
    typedef struct packed {
        logic [FIELD_W-1:0] num_m1;
        logic [FIELD_W-1:0] den_m1;
    } ratio_t;
endpackage

// File: rtl/usec_regs.sv
// Register file: holds the ratio word and freeze bit, decodes writes and
// muxes read data. Assumes single-cycle write strobes; the counter view is
// read-only and writes to it or to unmapped offsets are dropped.
module usec_regs
    import usec_pkg::*;
#(
    parameter int          CNT_W     = 32,
    parameter logic [15:0] RATIO_RST = 16'h000b
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count_in,
    output logic [DATA_W-1:0] rdata,
    output ratio_t            ratio_q,
    output logic              freeze_q,
    output logic              ratio_wr
);
    localparam int RATIO_W = $bits(ratio_t);

    logic hold_wr;

    // Decode the write strobes per offset.
    always_comb begin
        ratio_wr = wr && (addr == OFF_RATIO);
        hold_wr  = wr && (addr == OFF_HOLD);
    end

    // Store the ratio word; only the low 16 bits are kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_q <= ratio_t'(RATIO_RST);
        end else if (ratio_wr) begin
            ratio_q <= ratio_t'(wdata[RATIO_W-1:0]);
        end
    end

    // Store the freeze control bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freeze_q <= 1'b0;
        end else if (hold_wr) begin
            freeze_q <= wdata[0];
        end
    end

    // Select read data for the addressed offset.
    always_comb begin
        rdata = '0;
        case (addr)
            OFF_COUNT: rdata = DATA_W'(count_in);
            OFF_RATIO: rdata = DATA_W'(ratio_q);
            OFF_HOLD:  rdata = DATA_W'(freeze_q);
            default:   rdata = '0;
        endcase
    end

    // R9: a freeze write is visible on the next cycle.
    p_freeze_rb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_wr |=> (freeze_q == $past(wdata[0])));

    // R9: a ratio write is stored as its low 16 bits.
    p_ratio_rb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_wr |=> (ratio_q == $past(wdata[RATIO_W-1:0])));
endmodule

// File: rtl/usec_prescaler.sv
// Rational prescaler: adds N each unfrozen cycle to a phase accumulator and
// fires when the sum reaches D, then subtracts D. Assumes the ratio fields
// arrive minus-one encoded. The residue is clamped below D so at most one
// tick can fire per cycle, even when N exceeds D.
module usec_prescaler
    import usec_pkg::*;
#(
    parameter int FW = FIELD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] num_m1,
    input  logic [FW-1:0] den_m1,
    input  logic          cfg_wr,
    input  logic          freeze,
    output logic          fire_o,
    output logic          tick_o
);
    localparam int SUM_W = FW + 2;

    logic [FW-1:0]    acc_q;
    logic [FW-1:0]    acc_d;
    logic [SUM_W-1:0] num;
    logic [SUM_W-1:0] den;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] resid;
    logic             reach;

    // Form the step sum and decide whether this cycle fires.
    always_comb begin
        num    = SUM_W'(num_m1) + SUM_W'(1);
        den    = SUM_W'(den_m1) + SUM_W'(1);
        sum    = SUM_W'(acc_q) + num;
        resid  = sum - den;
        reach  = (sum >= den);
        fire_o = reach && !freeze && !cfg_wr;
    end

    // Choose the next accumulator value: clear, hold, or step.
    always_comb begin
        if (cfg_wr) begin
            acc_d = '0;
        end else if (freeze) begin
            acc_d = acc_q;
        end else if (reach) begin
            acc_d = (resid > SUM_W'(den_m1)) ? den_m1 : resid[FW-1:0];
        end else begin
            acc_d = sum[FW-1:0];
        end
    end

    // Register the accumulator and the tick pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            tick_o <= 1'b0;
        end else begin
            acc_q  <= acc_d;
            tick_o <= fire_o;
        end
    end

    // R3: the residue stays below D, so no backlog of ticks can build.
    p_acc_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (SUM_W'(acc_q) <= SUM_W'(den_m1)) || $past(cfg_wr));

    // R5: a ratio write restarts the phase and suppresses the tick (R7).
    p_clear_on_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (acc_q == '0) && !tick_o);

    // R6: frozen cycles hold the phase and emit nothing.
    p_hold_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !cfg_wr) |=> $stable(acc_q) && !tick_o);
endmodule

// File: rtl/usec_counter.sv
// Free-running microsecond counter: advances by one on each fire strobe and
// wraps at its width. Assumes the strobe is at most one per cycle.
module usec_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [CNT_W-1:0] count_o
);
    // Step the count upward on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (adv) begin
            count_o <= count_o + CNT_W'(1);
        end
    end

    // R4: without a strobe the count holds.
    p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(count_o));
endmodule

// File: rtl/usec_tick_counter.sv
// Top: fractional microsecond tick counter. Ties the register file, the
// rational prescaler and the counter together. Assumes one reference clock
// domain and a synchronous active-low reset.
module usec_tick_counter
    import usec_pkg::*;
#(
    parameter int          CNT_W     = 32,
    parameter logic [15:0] RATIO_RST = 16'h000b
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              tick_o,
    output logic [CNT_W-1:0]  count_o
);
    ratio_t ratio_q;
    logic   freeze_q;
    logic   ratio_wr;
    logic   fire;

    usec_regs #(.CNT_W(CNT_W), .RATIO_RST(RATIO_RST)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (reg_addr),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .count_in (count_o),
        .rdata    (reg_rdata),
        .ratio_q  (ratio_q),
        .freeze_q (freeze_q),
        .ratio_wr (ratio_wr)
    );

    usec_prescaler #(.FW(FIELD_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .num_m1 (ratio_q.num_m1),
        .den_m1 (ratio_q.den_m1),
        .cfg_wr (ratio_wr),
        .freeze (freeze_q),
        .fire_o (fire),
        .tick_o (tick_o)
    );

    usec_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (fire),
        .count_o (count_o)
    );

    // R4: each tick pulse coincides with a single-step advance of the count.
    p_tick_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> (count_o == $past(count_o) + CNT_W'(1)));

    // R7: a ratio write edge never advances the count.
    p_cfg_no_adv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_wr |=> $stable(count_o));
endmodule

// File: tb/usec_tick_counter_bench.sv
// Bench: directed corners plus seeded random stimulus, checked against a
// cycle model built from the requirements.
module usec_tick_counter_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_CNT  = 8'h10;
    localparam logic [7:0] A_RAT  = 8'h14;
    localparam logic [7:0] A_HOLD = 8'h4c;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tick_o;
    logic [31:0] count_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // model state
    int unsigned m_acc, m_cnt;
    logic [15:0] m_cfg;
    bit m_frz, m_tick;

    always #(CLK_PERIOD/2) clk = ~clk;

    usec_tick_counter u_usec_tick_counter (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_o(tick_o),
        .count_o(count_o)
    );

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            A_CNT:   return m_cnt;
            A_RAT:   return {16'h0, m_cfg};
            A_HOLD:  return {31'h0, m_frz};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_edge(input logic [7:0] a, input logic w, input logic [31:0] d);
        int unsigned num, den, sum;
        num = m_cfg[15:8] + 1;
        den = m_cfg[7:0] + 1;
        if (w && a == A_RAT) begin
            m_cfg = d[15:0]; m_acc = 0; m_tick = 0;
        end else if (m_frz) begin
            m_tick = 0;
        end else begin
            sum = m_acc + num;
            if (sum >= den) begin
                m_tick = 1;
                m_acc = (sum - den > den - 1) ? den - 1 : sum - den;
                m_cnt = m_cnt + 1;
            end else begin
                m_tick = 0;
                m_acc = sum;
            end
        end
        if (w && a == A_HOLD) m_frz = d[0];
    endtask

    // One cycle: drive, clock, update model, sample at the falling edge.
    task automatic step(input logic [7:0] a, input logic w, input logic [31:0] d);
        reg_addr = a; reg_wr = w; reg_wdata = d;
        @(posedge clk);
        model_edge(a, w, d);
        @(negedge clk);
        check("R2 tick", {31'h0, tick_o}, {31'h0, m_tick});
        check("R4 count", count_o, m_cnt);
        check("R9 read", reg_rdata, exp_read(a));
        reg_wr = 1'b0;
    endtask

    // Idle cycles reading one offset; returns ticks seen.
    task automatic idle(input int n, input logic [7:0] a, output int ticks);
        ticks = 0;
        for (int i = 0; i < n; i++) begin
            step(a, 1'b0, 32'h0);
            ticks += tick_o;
        end
    endtask

    initial begin
        int t;
        logic [31:0] c0;
        void'($urandom(32'd20240611));
        m_acc = 0; m_cnt = 0; m_cfg = 16'h000b; m_frz = 0; m_tick = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        reg_addr = A_RAT; #1;
        check("R1 ratio", reg_rdata, 32'h0000_000b);
        check("R1 count", count_o, 32'h0);
        check("R1 tick", {31'h0, tick_o}, 32'h0);
        reg_addr = A_HOLD; #1;
        check("R1 freeze", reg_rdata, 32'h0);
        @(negedge clk);

        // R5: first tick follows the 12th edge after a 0x000b write
        step(A_RAT, 1'b1, 32'h0000_000b);
        idle(11, A_CNT, t);
        check("R5 no early tick", t, 0);
        step(A_CNT, 1'b0, 32'h0);
        check("R5 twelfth edge tick", {31'h0, tick_o}, 32'h1);

        // R7: ratio write on the edge where a tick is due
        c0 = count_o;
        idle(11, A_CNT, t);
        step(A_RAT, 1'b1, 32'h0000_000b);
        check("R7 tick dropped", {31'h0, tick_o}, 32'h0);
        check("R7 count held", count_o, c0);

        // R10: 13-cycle group and 5-in-96 group
        step(A_RAT, 1'b1, 32'h0000_000c);
        idle(130, A_CNT, t);
        check("R10 13MHz", t, 10);
        step(A_RAT, 1'b1, 32'hffff_045f);
        check("R9 upper dropped", reg_rdata, 32'h0000_045f);
        idle(96 * 4, A_RAT, t);
        check("R10 19.2MHz", t, 20);
        step(A_RAT, 1'b1, 32'h0000_04bf);
        idle(192 * 2, A_CNT, t);
        check("R10 38.4MHz", t, 10);

        // R3: N above D gives one tick every cycle
        step(A_RAT, 1'b1, 32'h0000_0201);
        idle(40, A_CNT, t);
        check("R3 every cycle", t, 40);
        step(A_RAT, 1'b1, 32'h0000_ff00);
        idle(20, A_CNT, t);
        check("R3 max ratio", t, 20);

        // R6: freeze holds everything
        step(A_HOLD, 1'b1, 32'h1);
        c0 = count_o;
        idle(25, A_HOLD, t);
        check("R6 frozen ticks", t, 0);
        check("R6 frozen count", count_o, c0);
        step(A_HOLD, 1'b1, 32'h0);

        // R8: writes to count and unmapped offsets ignored
        c0 = count_o;
        step(A_RAT, 1'b1, 32'h0000_0063);
        step(A_CNT, 1'b1, 32'hdead_beef);
        check("R8 count not written", count_o, c0);
        step(8'h20, 1'b1, 32'h0000_0001);
        check("R8 unmapped reads zero", reg_rdata, 32'h0);
        step(A_RAT, 1'b0, 32'h0);
        check("R8 ratio unchanged", reg_rdata, 32'h0000_0063);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            logic [7:0] a;
            r = $urandom_range(0, 99);
            case ($urandom_range(0, 3))
                0: a = A_CNT;
                1: a = A_RAT;
                2: a = A_HOLD;
                default: a = 8'($urandom_range(0, 255));
            endcase
            if (r < 3)       step(A_RAT, 1'b1, $urandom & 32'h0000_07ff | 32'h0000_0008);
            else if (r < 6)  step(A_HOLD, 1'b1, $urandom_range(0, 3));
            else if (r < 9)  step(a, 1'b1, $urandom);
            else             step(a, 1'b0, 32'h0);
        end

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule